// File: doc/BRIEF.md
# Cartridge Bank Controller

This block sits between an 8-bit processor with a 16-bit address bus and the ROM and RAM chips of a plug-in cartridge. Processor writes that land in the lower 32 KiB (the ROM space) never reach memory. Instead, bits 14:13 of the address pick one of four control registers: a RAM unlock flag, a ROM bank number, a RAM bank number and a mode bit.

On every access the block widens the processor address. It produces a ROM address that reaches any fitted 16 KiB bank and a RAM address inside the selected 8 KiB bank. It gates the RAM write strobe, and it steers the read data back to the processor. Two static configuration inputs describe the board: how many ROM banks are fitted and how many RAM banks are fitted. A third input says whether RAM is present at all.

The address and read-data paths are combinational from the processor inputs and the stored registers. Register updates take effect on the clock edge at which the write strobe is high.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After synchronous reset the ROM bank register holds 1, the RAM bank register holds 0, RAM access is locked and `adv_mode` is 0.
- R2: A write anywhere in 0x0000–0x1FFF unlocks RAM when bits 3:0 of the data equal 0xA. Any other low nibble locks RAM again.
- R3: While `cfg_ram_present` is 0, writes to 0x0000–0x1FFF are ignored. RAM stays locked even if RAM is later reported present.
- R4: A write in 0x2000–0x3FFF loads the ROM bank register from data bits 4:0. Bits 7:5 are discarded.
- R5: A write in 0x4000–0x5FFF loads the two-bit RAM bank register from data bits 1:0.
- R6: A write in 0x6000–0x7FFF sets `adv_mode` to data bit 0.
- R7: For any address in 0x0000–0x3FFF, `rom_addr` equals the processor address (bank 0).
- R8: For an address in 0x4000–0x7FFF, `rom_addr` = bank × 0x4000 + (address & 0x3FFF).
- R9: The bank used in R8 never exceeds `cfg_rom_banks` − 1. A count of 0 yields bank 0.
- R10: For an address in 0xA000–0xBFFF, `ram_addr` = (address − 0xA000) + 0x2000 × RAM bank.
- R11: `cpu_rdata` returns `ram_rdata` for a RAM-window read only when RAM is present and the RAM bank is below `cfg_ram_banks`. Otherwise it returns 0xFF. Reads in 0x8000–0x9FFF and 0xC000–0xFFFF also return 0xFF. ROM-window reads return `rom_rdata`.
- R12: `ram_we` is high only for a write in the RAM window while RAM is present, unlocked and the RAM bank is below `cfg_ram_banks`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wr | input | 1 | Processor write strobe |
| cfg_rom_banks | input | 6 | Number of fitted 16 KiB ROM banks |
| cfg_ram_present | input | 1 | Cartridge RAM is fitted |
| cfg_ram_banks | input | 3 | Number of fitted 8 KiB RAM banks |
| rom_rdata | input | 8 | Data returned by the ROM |
| ram_rdata | input | 8 | Data returned by the RAM |
| rom_addr | output | 19 | Widened ROM address |
| ram_addr | output | 15 | Banked RAM address |
| ram_we | output | 1 | RAM write enable |
| ram_re | output | 1 | RAM read enable |
| ram_wdata | output | 8 | Data towards the RAM |
| cpu_rdata | output | 8 | Read data towards the processor |
| adv_mode | output | 1 | Stored banking mode bit |

## Verification
The hardest case to reach is a RAM bank that lies beyond the fitted RAM. It needs three things at once: the RAM unlocked, a bank value of 2 or 3 stored, and a board configured with fewer banks. The bench first unlocks RAM and stores bank 2. It then lowers `cfg_ram_banks` to 2 and checks that reads return 0xFF and writes are blocked. Finally it raises the count to 4 and checks that the same access now goes through.

The stuck lock after a write while RAM is absent is reached in a similar way. The bench writes the unlock value with RAM reported absent. It then reports RAM present and checks that RAM writes are still blocked.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  localparam int CPU_AW = 16;
  localparam int CPU_DW = 8;

  typedef enum logic [1:0] {
    CR_UNLOCK  = 2'd0,
    CR_ROMSEL  = 2'd1,
    CR_RAMSEL  = 2'd2,
    CR_MODESEL = 2'd3
  } ctl_reg_e;

  typedef enum logic [1:0] {
    WN_ROM_FIX,
    WN_ROM_SW,
    WN_XRAM,
    WN_NONE
  } window_e;

  function automatic window_e window_of(input logic [CPU_AW-1:0] a);
    if (a[15:14] == 2'b00)      return WN_ROM_FIX;
    else if (a[15:14] == 2'b01) return WN_ROM_SW;
    else if (a[15:13] == 3'b101) return WN_XRAM;
    else                        return WN_NONE;
  endfunction

  function automatic ctl_reg_e ctl_of(input logic [CPU_AW-1:0] a);
    return ctl_reg_e'(a[14:13]);
  endfunction
endpackage

// File: rtl/cbc_ctl_regs.sv
module cbc_ctl_regs
  import cbc_pkg::*;
#(
  parameter int ROM_BANK_W = 5,
  parameter int RAM_BANK_W = 2,
  parameter logic [3:0] UNLOCK_KEY = 4'hA
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [CPU_AW-1:0]     addr,
  input  logic [CPU_DW-1:0]     wdata,
  input  logic                  ram_present,
  output logic [ROM_BANK_W-1:0] rom_bank,
  output logic [RAM_BANK_W-1:0] ram_bank,
  output logic                  ram_unlocked,
  output logic                  mode
);
  logic hit;
  assign hit = wr_en && (addr[15] == 1'b0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_bank     <= ROM_BANK_W'(1);
      ram_bank     <= '0;
      ram_unlocked <= 1'b0;
      mode         <= 1'b0;
    end else if (hit) begin
      case (ctl_of(addr))
        CR_UNLOCK: begin
          if (ram_present) ram_unlocked <= (wdata[3:0] == UNLOCK_KEY);
        end
        CR_ROMSEL:  rom_bank <= wdata[ROM_BANK_W-1:0];
        CR_RAMSEL:  ram_bank <= wdata[RAM_BANK_W-1:0];
        CR_MODESEL: mode     <= wdata[0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cbc_rom_map.sv
module cbc_rom_map
  import cbc_pkg::*;
#(
  parameter int ROM_BANK_W = 5,
  parameter int BANK_OFS_W = 14,
  localparam int ROM_AW = ROM_BANK_W + BANK_OFS_W
) (
  input  logic [CPU_AW-1:0]     addr,
  input  logic [ROM_BANK_W-1:0] bank_reg,
  input  logic [ROM_BANK_W:0]   bank_count,
  output logic [ROM_AW-1:0]     rom_addr
);
  logic [ROM_BANK_W:0]   limit;
  logic [ROM_BANK_W-1:0] bank_eff;

  always_comb begin
    if (bank_count == '0) limit = '0;
    else                  limit = bank_count - 1'b1;
    if ({1'b0, bank_reg} > limit) bank_eff = limit[ROM_BANK_W-1:0];
    else                          bank_eff = bank_reg;
  end

  always_comb begin
    if (window_of(addr) == WN_ROM_SW)
      rom_addr = {bank_eff, addr[BANK_OFS_W-1:0]};
    else
      rom_addr = {{ROM_BANK_W{1'b0}}, addr[BANK_OFS_W-1:0]};
  end
endmodule

// File: rtl/cbc_ram_map.sv
module cbc_ram_map
  import cbc_pkg::*;
#(
  parameter int RAM_BANK_W = 2,
  parameter int RAM_OFS_W  = 13,
  localparam int RAM_AW = RAM_BANK_W + RAM_OFS_W
) (
  input  logic [CPU_AW-1:0]     addr,
  input  logic                  rd,
  input  logic                  wr,
  input  logic [RAM_BANK_W-1:0] bank,
  input  logic [RAM_BANK_W:0]   bank_count,
  input  logic                  present,
  input  logic                  unlocked,
  output logic [RAM_AW-1:0]     ram_addr,
  output logic                  in_reach,
  output logic                  ram_we,
  output logic                  ram_re
);
  logic in_win;

  assign in_win   = (window_of(addr) == WN_XRAM);
  assign ram_addr = {bank, addr[RAM_OFS_W-1:0]};
  assign in_reach = present && ({1'b0, bank} < bank_count);
  assign ram_re   = rd && in_win && in_reach;
  assign ram_we   = wr && in_win && in_reach && unlocked;
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cbc_pkg::*;
#(
  parameter int ROM_BANK_W = 5,
  parameter int RAM_BANK_W = 2,
  parameter int BANK_OFS_W = 14,
  parameter int RAM_OFS_W  = 13,
  localparam int ROM_AW = ROM_BANK_W + BANK_OFS_W,
  localparam int RAM_AW = RAM_BANK_W + RAM_OFS_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CPU_AW-1:0]     cpu_addr,
  input  logic [CPU_DW-1:0]     cpu_wdata,
  input  logic                  cpu_rd,
  input  logic                  cpu_wr,
  input  logic [ROM_BANK_W:0]   cfg_rom_banks,
  input  logic                  cfg_ram_present,
  input  logic [RAM_BANK_W:0]   cfg_ram_banks,
  input  logic [CPU_DW-1:0]     rom_rdata,
  input  logic [CPU_DW-1:0]     ram_rdata,
  output logic [ROM_AW-1:0]     rom_addr,
  output logic [RAM_AW-1:0]     ram_addr,
  output logic                  ram_we,
  output logic                  ram_re,
  output logic [CPU_DW-1:0]     ram_wdata,
  output logic [CPU_DW-1:0]     cpu_rdata,
  output logic                  adv_mode
);
  logic [ROM_BANK_W-1:0] rom_bank;
  logic [RAM_BANK_W-1:0] ram_bank;
  logic                  unlocked;
  logic                  ram_ok;

  cbc_ctl_regs #(
    .ROM_BANK_W(ROM_BANK_W),
    .RAM_BANK_W(RAM_BANK_W)
  ) u_regs (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (cpu_wr),
    .addr         (cpu_addr),
    .wdata        (cpu_wdata),
    .ram_present  (cfg_ram_present),
    .rom_bank     (rom_bank),
    .ram_bank     (ram_bank),
    .ram_unlocked (unlocked),
    .mode         (adv_mode)
  );

  cbc_rom_map #(
    .ROM_BANK_W(ROM_BANK_W),
    .BANK_OFS_W(BANK_OFS_W)
  ) u_rom (
    .addr       (cpu_addr),
    .bank_reg   (rom_bank),
    .bank_count (cfg_rom_banks),
    .rom_addr   (rom_addr)
  );

  cbc_ram_map #(
    .RAM_BANK_W(RAM_BANK_W),
    .RAM_OFS_W (RAM_OFS_W)
  ) u_ram (
    .addr       (cpu_addr),
    .rd         (cpu_rd),
    .wr         (cpu_wr),
    .bank       (ram_bank),
    .bank_count (cfg_ram_banks),
    .present    (cfg_ram_present),
    .unlocked   (unlocked && cfg_ram_present),
    .ram_addr   (ram_addr),
    .in_reach   (ram_ok),
    .ram_we     (ram_we),
    .ram_re     (ram_re)
  );

  assign ram_wdata = cpu_wdata;

  always_comb begin
    unique case (window_of(cpu_addr))
      WN_ROM_FIX, WN_ROM_SW: cpu_rdata = rom_rdata;
      WN_XRAM:               cpu_rdata = ram_ok ? ram_rdata : {CPU_DW{1'b1}};
      default:               cpu_rdata = {CPU_DW{1'b1}};
    endcase
  end
endmodule

// File: rtl/cbc_checker.sv
module cbc_checker #(
  parameter int ROM_BANK_W = 5,
  parameter int RAM_BANK_W = 2,
  parameter int BANK_OFS_W = 14,
  parameter int RAM_OFS_W  = 13
) (
  input logic                              clk,
  input logic                              rst,
  input logic [15:0]                       cpu_addr,
  input logic                              cpu_rd,
  input logic                              cpu_wr,
  input logic [ROM_BANK_W:0]               cfg_rom_banks,
  input logic                              cfg_ram_present,
  input logic [ROM_BANK_W+BANK_OFS_W-1:0]  rom_addr,
  input logic                              ram_we,
  input logic [7:0]                        cpu_rdata,
  input logic                              adv_mode
);
  logic [ROM_BANK_W:0] lim;
  assign lim = (cfg_rom_banks == '0) ? '0 : cfg_rom_banks - 1'b1;

  AST_FIXED_BANK: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr[15:14] == 2'b00) |-> (rom_addr == {{ROM_BANK_W-2{1'b0}}, 2'b00, cpu_addr[13:0]})); // R7

  AST_BANK_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr[15:14] == 2'b01) |-> ({1'b0, rom_addr[ROM_BANK_W+BANK_OFS_W-1:BANK_OFS_W]} <= lim)); // R9

  AST_WE_GATED: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (cpu_wr && cfg_ram_present && cpu_addr[15:13] == 3'b101)); // R12

  AST_ABSENT_FF: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr[15:13] == 3'b101 && !cfg_ram_present) |-> (cpu_rdata == 8'hFF)); // R11

  AST_MODE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (adv_mode != $past(adv_mode)) |-> $past(cpu_wr && cpu_addr[15:13] == 3'b011)); // R6
endmodule

bind cart_bank_ctrl cbc_checker #(
  .ROM_BANK_W(ROM_BANK_W),
  .RAM_BANK_W(RAM_BANK_W),
  .BANK_OFS_W(BANK_OFS_W),
  .RAM_OFS_W (RAM_OFS_W)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .cpu_addr        (cpu_addr),
  .cpu_rd          (cpu_rd),
  .cpu_wr          (cpu_wr),
  .cfg_rom_banks   (cfg_rom_banks),
  .cfg_ram_present (cfg_ram_present),
  .rom_addr        (rom_addr),
  .ram_we          (ram_we),
  .cpu_rdata       (cpu_rdata),
  .adv_mode        (adv_mode)
);

// File: tb/cart_bank_ctrl_tb.sv
module cart_bank_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [5:0]  cfg_rom_banks = 6'd32;
  logic        cfg_ram_present = 1'b1;
  logic [2:0]  cfg_ram_banks = 3'd4;
  logic [7:0]  rom_rdata = 8'h5A;
  logic [7:0]  ram_rdata = 8'h3C;
  logic [18:0] rom_addr;
  logic [14:0] ram_addr;
  logic        ram_we, ram_re, adv_mode;
  logic [7:0]  ram_wdata, cpu_rdata;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  cart_bank_ctrl u_dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cfg_rom_banks(cfg_rom_banks),
    .cfg_ram_present(cfg_ram_present), .cfg_ram_banks(cfg_ram_banks),
    .rom_rdata(rom_rdata), .ram_rdata(ram_rdata), .rom_addr(rom_addr),
    .ram_addr(ram_addr), .ram_we(ram_we), .ram_re(ram_re),
    .ram_wdata(ram_wdata), .cpu_rdata(cpu_rdata), .adv_mode(adv_mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic probe(input logic [15:0] a, input logic rd, input logic wr);
    @(negedge clk);
    cpu_addr = a; cpu_rd = rd; cpu_wr = wr;
    #1;
  endtask

  task automatic idle();
    cpu_rd = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic t_reset();
    probe(16'h4123, 1'b1, 1'b0);
    chk("R1 rom bank 1", 32'(rom_addr), 32'h04123);
    chk("R1 simple mode", 32'(adv_mode), 32'd0);
    probe(16'hA005, 1'b0, 1'b1);
    chk("R1 ram locked", 32'(ram_we), 32'd0);
    chk("R1 ram bank 0", 32'(ram_addr), 32'h0005);
    idle();
  endtask

  task automatic t_unlock();
    reg_write(16'h0000, 8'h1A);
    probe(16'hA010, 1'b0, 1'b1);
    chk("R2 unlock via 0xA nibble", 32'(ram_we), 32'd1);
    chk("R2 write data passes", 32'(ram_wdata), 32'h1A);
    idle();
    reg_write(16'h1FFF, 8'h0B);
    probe(16'hA010, 1'b0, 1'b1);
    chk("R2 relock on other nibble", 32'(ram_we), 32'd0);
    idle();
  endtask

  task automatic t_absent();
    cfg_ram_present = 1'b0;
    reg_write(16'h0800, 8'h0A);
    probe(16'hA000, 1'b1, 1'b0);
    chk("R11 absent ram reads ff", 32'(cpu_rdata), 32'hFF);
    idle();
    cfg_ram_present = 1'b1;
    probe(16'hA000, 1'b0, 1'b1);
    chk("R3 unlock ignored while absent", 32'(ram_we), 32'd0);
    idle();
  endtask

  task automatic t_rom_bank();
    cfg_rom_banks = 6'd32;
    reg_write(16'h2000, 8'hE7);
    probe(16'h7FFF, 1'b1, 1'b0);
    chk("R4 low five bits", 32'(rom_addr), 32'h1FFFF);
    chk("R8 banked address", 32'(cpu_rdata), 32'h5A);
    probe(16'h3ABC, 1'b1, 1'b0);
    chk("R7 fixed window", 32'(rom_addr), 32'h03ABC);
    idle();
  endtask

  task automatic t_clamp();
    cfg_rom_banks = 6'd8;
    reg_write(16'h3000, 8'h1F);
    probe(16'h4000, 1'b1, 1'b0);
    chk("R9 clamp to count-1", 32'(rom_addr), 32'h1C000);
    cfg_rom_banks = 6'd0;
    probe(16'h4001, 1'b1, 1'b0);
    chk("R9 zero count gives bank 0", 32'(rom_addr), 32'h00001);
    idle();
    cfg_rom_banks = 6'd32;
  endtask

  task automatic t_ram_bank();
    reg_write(16'h0000, 8'h0A);
    reg_write(16'h4000, 8'hFE);
    cfg_ram_banks = 3'd2;
    probe(16'hA123, 1'b1, 1'b0);
    chk("R10 ram address", 32'(ram_addr), 32'h4123);
    chk("R11 bank beyond size reads ff", 32'(cpu_rdata), 32'hFF);
    probe(16'hA123, 1'b0, 1'b1);
    chk("R12 write beyond size blocked", 32'(ram_we), 32'd0);
    cfg_ram_banks = 3'd4;
    #1;
    chk("R12 write in range allowed", 32'(ram_we), 32'd1);
    probe(16'hBFFF, 1'b1, 1'b0);
    chk("R5 bank from bits 1:0", 32'(ram_addr), 32'h5FFF);
    chk("R11 in range returns ram data", 32'(cpu_rdata), 32'h3C);
    idle();
  endtask

  task automatic t_mode();
    reg_write(16'h6000, 8'h03);
    #1;
    chk("R6 advanced mode", 32'(adv_mode), 32'd1);
    reg_write(16'h7FFF, 8'h02);
    #1;
    chk("R6 simple mode", 32'(adv_mode), 32'd0);
  endtask

  task automatic t_holes();
    probe(16'h8000, 1'b1, 1'b0);
    chk("R11 hole at 0x8000 reads ff", 32'(cpu_rdata), 32'hFF);
    probe(16'hC000, 1'b1, 1'b1);
    chk("R11 hole at 0xC000 reads ff", 32'(cpu_rdata), 32'hFF);
    chk("R12 no write outside window", 32'(ram_we), 32'd0);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_unlock();
    t_absent();
    t_rom_bank();
    t_clamp();
    t_ram_bank();
    t_mode();
    t_holes();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    #2000000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule